// File: doc/BRIEF.md
# Weighted ROM Trajectory Generator

This block generates the reference path that a measured phase error is steered along while a phase lock converges. When the run input goes high, it captures the phase error present at that moment. It then walks an address through two stored gain curves. Both curves start at a gain of one and fall to zero at the last point. At every point the two curves are mixed by a run-time weight, and the mixed gain scales the captured error. The result is a reference that shrinks from the starting error down to zero.

The address advances once per programmable interval of system clocks. A signed correction from an external rate-feedback stage is added to that interval, and it is read again on every cycle, so the path can be stretched or squeezed while a run is in progress. The block also outputs the tracking difference, which is the reference minus the live phase error. This difference is multiplied by a gain that rises linearly from zero to one after the start, so early transients reach a downstream controller only weakly.

A small state machine sequences the run. It has three states: IDLE (waiting, outputs zero), TRACK (walking the curves) and HOLD (curve finished, reference held at zero). It has four named transitions: launch (IDLE to TRACK when run is high), finish (TRACK to HOLD when the last point's interval ends), abort (TRACK to IDLE when run drops) and release (HOLD to IDLE when run drops).

Top module: `traj_gen`

## Requirements
- R1: With L = DEPTH-1 and F = 2^15, stored point n of the upper curve is floor(F*(L-n)/L) and of the lower curve is floor(F*(L-n)^2/L^2). Point 0 is therefore 1.0 and point L is 0 in both curves.
- R2: The weight a is alpha-0x8000 when alpha >= 0x8000 and 0 otherwise. The mixed gain is floor((a*upper(n) + (32768-a)*lower(n)) / 32768).
- R3: On the launch edge the block captures phase_err as the start error. traj_out equals floor(gain*start_error/32768), saturated to 16-bit signed, and later phase_err values do not change it.
- R4: traj_out and diff_out are registered: the value visible after a clock edge is computed from the state, address and inputs before that edge.
- R5: curve_addr is 0 at launch and advances by exactly one at the end of each effective interval while in TRACK.
- R6: The effective interval is step_ivl + step_adj (step_adj is 8-bit two's complement), with a minimum of 1 clock. It is re-evaluated on every cycle, so a change during a run takes effect immediately.
- R7: The ramp gain starts at 0 at launch, rises by 2^-RF every RSTEP clocks outside IDLE, and stops at 1.0. The defaults (RF=15, RSTEP=3) give 98304 clocks, about 1.2 ms at 80 MHz.
- R8: diff_out is floor((reference - phase_err) * ramp), saturated to 16-bit signed. The reference is the same value that traj_out receives.
- R9: When the interval of the last point ends with run high, the state becomes HOLD. done is then 1, curve_addr stays at L, and traj_out becomes 0.
- R10: If run is low in TRACK or HOLD, the state returns to IDLE and curve_addr becomes 0. traj_out and diff_out are 0 after the following edge.
- R11: After reset the state is IDLE and traj_out, diff_out, curve_addr and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to start and keep a run going |
| phase_err | input | 16 | Measured phase error, signed |
| alpha | input | 16 | Curve weight, offset binary |
| step_ivl | input | 16 | Base clocks per curve point |
| step_adj | input | 8 | Signed interval correction |
| traj_out | output | 16 | Reference trajectory, signed |
| diff_out | output | 16 | Ramped tracking difference, signed |
| curve_addr | output | 10 | Current curve point |
| done | output | 1 | High in HOLD |

## Verification
The in-line assertions watch, on every cycle, the properties that need no arithmetic model. In IDLE both outputs are quiet on the next edge. The curve address never jumps by more than one point. The reference is zero once HOLD is reached. The reference never exceeds the captured error in magnitude. The ramp gain never decreases, and it never passes one. A step is never followed by another unless the interval has reached its minimum. The exact values need the bench's scenarios to show them: the arithmetic of the mixed gain, alpha clamping, saturation of the difference, interval changes in the middle of a run, and abort.

// File: rtl/traj_pkg.sv
package traj_pkg;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_TRACK = 2'd1,
        TS_HOLD  = 2'd2
    } trk_state_e;

    // Linear falling curve, 1.0 at point 0, zero at point last.
    function automatic longint upper_pt(int n, int last, int fb);
        return ((longint'(1) << fb) * longint'(last - n)) / longint'(last);
    endfunction

    // Square-law falling curve, steeper at the start, same endpoints.
    function automatic longint lower_pt(int n, int last, int fb);
        return ((longint'(1) << fb) * longint'(last - n) * longint'(last - n))
               / (longint'(last) * longint'(last));
    endfunction

endpackage

// File: rtl/traj_gain_rom.sv
module traj_gain_rom #(
    parameter int DEPTH = 1024,
    parameter int GF    = 15,
    localparam int ADDRW = $clog2(DEPTH)
) (
    input  logic [ADDRW-1:0] addr,
    output logic [GF:0]      up,
    output logic [GF:0]      lo
);
    logic [GF:0] up_tab [DEPTH];
    logic [GF:0] lo_tab [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_pt
        assign up_tab[i] = (GF+1)'(traj_pkg::upper_pt(i, DEPTH-1, GF));
        assign lo_tab[i] = (GF+1)'(traj_pkg::lower_pt(i, DEPTH-1, GF));
    end

    assign up = up_tab[addr];
    assign lo = lo_tab[addr];
endmodule

// File: rtl/traj_blend.sv
module traj_blend #(
    parameter int EW   = 16,
    parameter int GF   = 15,
    parameter int AW_A = 16
) (
    input  logic [GF:0]           up,
    input  logic [GF:0]           lo,
    input  logic [AW_A-1:0]       alpha,
    input  logic signed [EW-1:0]  err0,
    input  logic                  zero_gain,
    output logic signed [EW-1:0]  traj
);
    localparam int AF  = AW_A - 1;
    localparam int BW  = GF + AF + 3;
    localparam int TPW = EW + GF + 2;
    localparam longint HI_L = (longint'(1) << (EW-1)) - 1;
    localparam logic signed [TPW-1:0] HI = TPW'(HI_L);
    localparam logic signed [TPW-1:0] LO = TPW'(-HI_L - 1);

    logic [AF-1:0]         a_w;
    logic [AF:0]           wa, wb;
    logic [BW-1:0]         mix;
    logic [GF:0]           gain;
    logic signed [TPW-1:0] prod, shd;

    always_comb begin
        // offset-binary weight, below the zero code clamps to zero
        a_w  = alpha[AW_A-1] ? alpha[AF-1:0] : '0;
        wa   = {1'b0, a_w};
        wb   = (AF+1)'(1 << AF) - wa;
        mix  = BW'(up) * BW'(wa) + BW'(lo) * BW'(wb);
        gain = zero_gain ? '0 : (GF+1)'(mix >> AF);
        prod = TPW'(err0) * TPW'($signed({1'b0, gain}));
        shd  = prod >>> GF;
        if (shd > HI)      traj = EW'(HI);
        else if (shd < LO) traj = EW'(LO);
        else               traj = EW'(shd);
    end
endmodule

// File: rtl/traj_step_timer.sv
module traj_step_timer #(
    parameter int IVW  = 16,
    parameter int ADJW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   en,
    input  logic [IVW-1:0]         ivl,
    input  logic signed [ADJW-1:0] adj,
    output logic                   step
);
    localparam int SW = IVW + 2;

    logic signed [SW-1:0] sum;
    logic [IVW:0]         eff_m1;
    logic [IVW:0]         tick;

    always_comb begin
        sum = $signed({2'b00, ivl}) + SW'(adj);
        if (sum <= SW'(1)) eff_m1 = '0;
        else               eff_m1 = (IVW+1)'(sum - SW'(1));
        step = en && (tick >= eff_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    tick <= '0;
        else if (clr)  tick <= '0;
        else if (en)   tick <= step ? '0 : tick + 1'b1;
    end

    // R6: after a step the next one waits at least a clock unless the interval is at its floor
    assert_step_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && step && eff_m1 != '0) |=> (!step || eff_m1 == '0 || clr));
endmodule

// File: rtl/traj_ramp.sv
module traj_ramp #(
    parameter int RF    = 15,
    parameter int RSTEP = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    output logic [RF:0] ramp
);
    localparam int DW = (RSTEP > 1) ? $clog2(RSTEP) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(RSTEP - 1);
    localparam logic [RF:0]   R_ONE    = {1'b1, {RF{1'b0}}};

    logic [DW-1:0] div;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ramp <= '0;
            div  <= '0;
        end else if (en && ramp != R_ONE) begin
            if (div == DIV_LAST) begin
                div  <= '0;
                ramp <= ramp + 1'b1;
            end else begin
                div  <= div + 1'b1;
            end
        end
    end

    assert_ramp_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (ramp >= $past(ramp)));
    assert_ramp_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ramp <= R_ONE);
endmodule

// File: rtl/traj_gen.sv
module traj_gen
    import traj_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int EW    = 16,
    parameter int GF    = 15,
    parameter int AW_A  = 16,
    parameter int IVW   = 16,
    parameter int ADJW  = 8,
    parameter int RF    = 15,
    parameter int RSTEP = 3,
    localparam int ADDRW = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic signed [EW-1:0]   phase_err,
    input  logic [AW_A-1:0]        alpha,
    input  logic [IVW-1:0]         step_ivl,
    input  logic signed [ADJW-1:0] step_adj,
    output logic signed [EW-1:0]   traj_out,
    output logic signed [EW-1:0]   diff_out,
    output logic [ADDRW-1:0]       curve_addr,
    output logic                   done
);
    localparam logic [ADDRW-1:0] LAST = ADDRW'(DEPTH - 1);
    localparam int DPW = EW + RF + 3;
    localparam longint HI_L = (longint'(1) << (EW-1)) - 1;
    localparam logic signed [DPW-1:0] DHI = DPW'(HI_L);
    localparam logic signed [DPW-1:0] DLO = DPW'(-HI_L - 1);

    trk_state_e state, state_nx;

    logic [ADDRW-1:0]       addr_q;
    logic signed [EW-1:0]   err0_q;
    logic [GF:0]            up_w, lo_w;
    logic signed [EW-1:0]   traj_c, diff_c;
    logic                   step_w;
    logic [RF:0]            ramp_w;
    logic signed [DPW-1:0]  dsub, dprod, dshd;

    traj_gain_rom #(.DEPTH(DEPTH), .GF(GF)) u_rom (
        .addr (addr_q),
        .up   (up_w),
        .lo   (lo_w)
    );

    traj_blend #(.EW(EW), .GF(GF), .AW_A(AW_A)) u_blend (
        .up        (up_w),
        .lo        (lo_w),
        .alpha     (alpha),
        .err0      (err0_q),
        .zero_gain (state != TS_TRACK),
        .traj      (traj_c)
    );

    traj_step_timer #(.IVW(IVW), .ADJW(ADJW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == TS_IDLE),
        .en    (state == TS_TRACK),
        .ivl   (step_ivl),
        .adj   (step_adj),
        .step  (step_w)
    );

    traj_ramp #(.RF(RF), .RSTEP(RSTEP)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == TS_IDLE),
        .en    (state != TS_IDLE),
        .ramp  (ramp_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_IDLE;
        else        state <= state_nx;
    end

    // transitions: launch, finish, abort, release
    always_comb begin
        state_nx = state;
        unique case (state)
            TS_IDLE:  if (run) state_nx = TS_TRACK;
            TS_TRACK: begin
                if (!run)                         state_nx = TS_IDLE;
                else if (step_w && addr_q == LAST) state_nx = TS_HOLD;
            end
            TS_HOLD:  if (!run) state_nx = TS_IDLE;
        endcase
    end

    // address and captured start error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            err0_q <= '0;
        end else begin
            unique case (state)
                TS_IDLE: begin
                    addr_q <= '0;
                    if (run) err0_q <= phase_err;
                end
                TS_TRACK: begin
                    if (!run)                         addr_q <= '0;
                    else if (step_w && addr_q != LAST) addr_q <= addr_q + 1'b1;
                end
                TS_HOLD:  if (!run) addr_q <= '0;
            endcase
        end
    end

    // ramped tracking difference
    always_comb begin
        dsub  = DPW'(traj_c) - DPW'(phase_err);
        dprod = dsub * DPW'($signed({1'b0, ramp_w}));
        dshd  = dprod >>> RF;
        if (dshd > DHI)      diff_c = EW'(DHI);
        else if (dshd < DLO) diff_c = EW'(DLO);
        else                 diff_c = EW'(dshd);
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            traj_out <= '0;
            diff_out <= '0;
        end else if (state == TS_IDLE) begin
            traj_out <= '0;
            diff_out <= '0;
        end else begin
            traj_out <= traj_c;
            diff_out <= diff_c;
        end
    end

    assign curve_addr = addr_q;
    assign done       = (state == TS_HOLD);

    int mag_t, mag_e;
    always_comb begin
        mag_t = (traj_out < 0) ? -int'(traj_out) : int'(traj_out);
        mag_e = (err0_q   < 0) ? -int'(err0_q)   : int'(err0_q);
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_IDLE) |=> (traj_out == '0 && diff_out == '0));
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_TRACK && run) |=>
        (curve_addr == $past(curve_addr) || curve_addr == $past(curve_addr) + 1'b1));
    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_HOLD) |=> (traj_out == '0));
    assert_traj_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mag_t <= mag_e);
endmodule

// File: tb/traj_gen_test.sv
`timescale 1ns/1ps
module traj_gen_test;
    localparam int DEPTH = 64, LAST = 63, RF = 6, RSTEP = 2, GF = 15;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n, run, done;
    logic signed [15:0] phase_err, traj_out, diff_out;
    logic [15:0]        alpha, step_ivl;
    logic signed [7:0]  step_adj;
    logic [5:0]         curve_addr;

    traj_gen #(.DEPTH(DEPTH), .RF(RF), .RSTEP(RSTEP)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .phase_err(phase_err),
        .alpha(alpha), .step_ivl(step_ivl), .step_adj(step_adj),
        .traj_out(traj_out), .diff_out(diff_out),
        .curve_addr(curve_addr), .done(done));

    int total = 0, bad = 0;

    function automatic longint f_up(int n);
        return (longint'(32768) * (LAST - n)) / LAST;
    endfunction
    function automatic longint f_lo(int n);
        return (longint'(32768) * (LAST - n) * (LAST - n)) / (LAST * LAST);
    endfunction
    function automatic longint f_gain(int n, logic [15:0] al);
        longint a;
        a = (al >= 16'h8000) ? longint'(al) - 32768 : 0;
        return (a * f_up(n) + (32768 - a) * f_lo(n)) >> 15;
    endfunction
    function automatic longint f_sat(longint x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction
    function automatic int f_eff(logic [15:0] iv, logic signed [7:0] ad);
        int s;
        s = int'(iv) + int'(ad);
        return (s < 1) ? 1 : s;
    endfunction

    // cycle model built from the requirements
    int     m_st, m_addr, m_tick, m_div;
    longint m_ramp, m_err0, e_traj, e_diff;

    task automatic ramp_adv();
        if (m_ramp != (1 << RF)) begin
            if (m_div == RSTEP - 1) begin m_div = 0; m_ramp++; end
            else m_div++;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_tick = 0; m_div = 0;
            m_ramp = 0; m_err0 = 0; e_traj = 0; e_diff = 0;
        end else begin
            longint g, tr, pe;
            int eff;
            bit stp;
            pe = longint'(phase_err);
            g  = (m_st == 1) ? f_gain(m_addr, alpha) : 0;
            tr = f_sat((m_err0 * g) >>> GF);
            if (m_st == 0) begin e_traj = 0; e_diff = 0; end
            else begin e_traj = tr; e_diff = f_sat(((tr - pe) * m_ramp) >>> RF); end
            case (m_st)
                0: begin
                    m_tick = 0; m_ramp = 0; m_div = 0; m_addr = 0;
                    if (run) begin m_st = 1; m_err0 = pe; end
                end
                1: begin
                    eff = f_eff(step_ivl, step_adj);
                    stp = (m_tick >= eff - 1);
                    ramp_adv();
                    m_tick = stp ? 0 : m_tick + 1;
                    if (!run) begin m_st = 0; m_addr = 0; end
                    else if (stp) begin
                        if (m_addr == LAST) m_st = 2; else m_addr++;
                    end
                end
                default: begin
                    ramp_adv();
                    if (!run) begin m_st = 0; m_addr = 0; end
                end
            endcase
        end
    end

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check("R3 R4 traj", longint'(traj_out), e_traj);
        check("R7 R8 diff", longint'(diff_out), e_diff);
        check("R5 R6 addr", longint'(curve_addr), longint'(m_addr));
        check("R9 done", longint'(done), longint'(m_st == 2));
    endtask

    task automatic launch(longint err);
        phase_err = 16'(err);
        run = 1'b1;
        cyc();                       // launch edge
        phase_err = 16'($urandom);
        cyc();                       // point 0 visible
        check("R1 first point equals start error", longint'(traj_out), err);
    endtask

    task automatic run_to_done(bit rnd_pe, bit rnd_adj);
        for (int i = 0; i < 6000 && !done; i++) begin
            if (rnd_pe)  phase_err = 16'($urandom);
            if (rnd_adj && ($urandom % 16) == 0) step_adj = 8'(int'($urandom % 7) - 3);
            cyc();
        end
        check("R9 reached hold", longint'(done), 1);
        check("R9 addr holds at last", longint'(curve_addr), LAST);
        cyc();
        check("R9 traj zero in hold", longint'(traj_out), 0);
        run = 1'b0;
        cyc(); cyc();
        check("R10 release quiet", longint'(traj_out) + longint'(diff_out), 0);
    endtask

    initial begin
        void'($urandom(32'd8191));
        rst_n = 1'b0; run = 1'b0; phase_err = '0;
        alpha = 16'h8000; step_ivl = 16'd3; step_adj = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check("R11 reset traj", longint'(traj_out), 0);
        check("R11 reset diff", longint'(diff_out), 0);
        check("R11 reset addr", longint'(curve_addr), 0);
        check("R11 reset done", longint'(done), 0);

        // lower curve only, steady measurement
        alpha = 16'h8000; step_ivl = 16'd3;
        launch(20000);
        phase_err = 16'sd5000;
        run_to_done(1'b0, 1'b0);

        // R2: alpha below the zero code behaves as zero weight
        alpha = 16'h1234; step_ivl = 16'd2;
        launch(-12345);
        run_to_done(1'b1, 1'b0);

        // full weight on upper curve, extreme negative start, adjust mid-run
        alpha = 16'hFFFF; step_ivl = 16'd4;
        launch(-32768);
        run_to_done(1'b1, 1'b1);
        step_adj = '0;

        // R10: abort in the middle of a run
        alpha = 16'hA000; step_ivl = 16'd5;
        launch(15000);
        repeat (50) cyc();
        run = 1'b0;
        cyc(); cyc();
        check("R10 abort traj", longint'(traj_out), 0);
        check("R10 abort diff", longint'(diff_out), 0);
        check("R10 abort addr", longint'(curve_addr), 0);

        // R6: negative sum clamps to one clock per point
        step_ivl = 16'd1; step_adj = -8'sd5;
        launch(9000);
        repeat (10) cyc();
        check("R6 one clock per point", longint'(curve_addr), 11);
        run_to_done(1'b1, 1'b0);
        step_adj = '0;

        // R8: saturation once the ramp is full
        alpha = 16'hC000; step_ivl = 16'd6;
        launch(32767);
        phase_err = -16'sd32768;
        repeat (140) cyc();
        check("R8 saturated diff", longint'(diff_out), 32767);
        run_to_done(1'b0, 1'b0);

        // random runs
        for (int r = 0; r < 6; r++) begin
            alpha    = 16'($urandom);
            step_ivl = 16'(1 + $urandom % 5);
            step_adj = 8'(int'($urandom % 5) - 2);
            launch(longint'($signed(16'($urandom))));
            run_to_done(1'b1, 1'b1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule